// File: doc/BRIEF.md
# Posted-Write Buffer with I/O Read Ordering Interlock

This block sits between a processor core and a single external bus. Core writes are posted into a small FIFO and drained to the bus in the background, so the core does not wait for them. A core read is served ahead of any buffered writes. Letting a read overtake writes is safe for ordinary memory but not for I/O devices. A device's data register may depend on a control write that is still waiting in the buffer.

To keep I/O accesses in order, every read bus cycle that begins while the buffer holds data carries an inhibit strobe. A device that recognises its address answers with an active-low decode signal and must ignore an inhibited access. When the block sees decode on an inhibited read, it throws the returned data away and drains every buffered write in order. It then issues the read again without inhibit. The core stays stalled until that replayed read completes. An address window that never answers with decode, such as a bulk data port, behaves as memory: it may overtake buffered writes, is never replayed, and stays cacheable. Each completed read returns a cacheable flag that is cleared when the page is marked cache-inhibited or when the device answered with decode.

Top module: `wbio_top`

## Requirements
- R1: A core write is accepted (core_ready high with core_we high) in the cycle it is presented when the buffer is not full and no read is in progress. Accepted writes reach the bus in acceptance order with their address and data unchanged.
- R2: The buffer holds DEPTH entries. While it is full, a core write is not accepted and core_ready stays low.
- R3: When the bus is free and both a core read and buffered writes are waiting, the read is issued to the bus first.
- R4: bus_inhibit is high during a read bus cycle that starts while the buffer is not empty. It is low on a read cycle that starts with an empty buffer, low on every write cycle, and low on a replayed read.
- R5: If bus_decode_n is low (decode asserted) at the ack of an inhibited read, the returned data is discarded and core_ready stays low. Every buffered write is then issued in order, and the read is reissued with bus_inhibit low. The core receives the data of the reissued read.
- R6: If bus_decode_n is high at the ack of an inhibited read, the read completes at once with the bus data, and the buffered writes stay buffered and drain afterwards.
- R7: core_rcache at read completion is high exactly when core_ci was low for that read and bus_decode_n was high at its ack.
- R8: From a decode response on an inhibited read until the replayed read is acknowledged, core_ready stays low.
- R9: Only one bus cycle is outstanding at a time. While bus_req is high and bus_ack is low, bus_req, bus_we, bus_addr, bus_wdata and bus_inhibit hold their values into the next cycle.
- R10: While rst_n is low (synchronous, active low), and after it rises, bus_req is low, the buffer is empty, and core_ready is low unless the core presents a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_req | input | 1 | Core request valid, held until core_ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Request address |
| core_wdata | input | DATA_W | Write data |
| core_ci | input | 1 | Page-level cache-inhibit bit for the request |
| core_ready | output | 1 | Request accepted (write) or completed (read) this cycle |
| core_rdata | output | DATA_W | Read data, valid with core_ready on a read |
| core_rcache | output | 1 | Read result may be cached, valid with core_ready on a read |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_inhibit | output | 1 | Devices must ignore this read |
| bus_ack | input | 1 | Bus cycle ends this clock |
| bus_decode_n | input | 1 | Active-low device decode, sampled with bus_ack |
| bus_rdata | input | DATA_W | Bus read data, sampled with bus_ack |

## Verification
The bench builds the block with its defaults: a four-entry buffer and 16-bit address and data. Four posted writes against a stalled bus reach the full condition, and a held write then shows the stall on full. A device stub answers with decode for the top address window, stays silent in a data-port window and a memory window, and inserts zero to two wait states at random. A hold control lets directed cases stage a read behind an in-flight write, which is where read priority, the flush-and-replay sequence and an overtaking data-port read become visible on the bus.

// File: rtl/wbio_pkg.sv
// Shared types for the posted-write buffer with I/O read interlock.
package wbio_pkg;
    // Bus sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,    // no bus cycle
        ST_WR,      // background drain of one buffered write
        ST_RD,      // first attempt of a core read
        ST_FLUSH,   // draining writes after a decode on an inhibited read
        ST_REPLAY   // read reissued without inhibit
    } wb_state_e;
endpackage

// File: rtl/wbio_fifo.sv
// Posted-write FIFO of address/data pairs.
// Assumes push is never raised while full and pop never while empty.
// Head outputs stay valid and stable until the entry is popped.
module wbio_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    output logic              last
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_mem[i] <= '0;
                data_mem[i] <= '0;
            end else if (push && wr_ptr == PW'(i)) begin
                addr_mem[i] <= push_addr;
                data_mem[i] <= push_data;
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Head and status flags.
    always_comb begin
        head_addr = addr_mem[rd_ptr];
        head_data = data_mem[rd_ptr];
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        last      = (count == CW'(1));
    end
endmodule

// File: rtl/wbio_ctrl.sv
// Bus sequencer: gives core reads priority, drains posted writes,
// marks reads that overtake writes with inhibit, and on a device decode
// flushes the buffer and replays the read. One bus cycle at a time;
// bus outputs come from registered state and stay put until bus_ack.
module wbio_ctrl
    import wbio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_ci,
    output logic              core_ready,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_rcache,
    input  logic              buf_full,
    input  logic              buf_empty,
    input  logic              buf_last,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    output logic              push,
    output logic              pop,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_inhibit,
    input  logic              bus_ack,
    input  logic              bus_decode_n,
    input  logic [DATA_W-1:0] bus_rdata
);
    wb_state_e         state_q, state_d;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_ci_q;
    logic              inh_q;
    logic              rd_cyc, wr_cyc, retry, rd_done, wr_ok;

    // Bus drive, core handshake and FIFO control.
    always_comb begin
        rd_cyc      = (state_q == ST_RD) || (state_q == ST_REPLAY);
        wr_cyc      = (state_q == ST_WR) || (state_q == ST_FLUSH);
        bus_req     = rd_cyc || wr_cyc;
        bus_we      = wr_cyc;
        bus_addr    = wr_cyc ? head_addr : rd_addr_q;
        bus_wdata   = head_data;
        bus_inhibit = (state_q == ST_RD) && inh_q;
        retry       = bus_inhibit && bus_ack && !bus_decode_n;
        rd_done     = rd_cyc && bus_ack && !retry;
        wr_ok       = ((state_q == ST_IDLE) || (state_q == ST_WR)) && !buf_full;
        push        = core_req && core_we && wr_ok;
        pop         = wr_cyc && bus_ack;
        core_ready  = core_req && (core_we ? wr_ok : rd_done);
        core_rdata  = bus_rdata;
        core_rcache = !rd_ci_q && bus_decode_n;
    end

    // Next-state selection; reads win over drains when the bus is free.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (core_req && !core_we) state_d = ST_RD;
                else if (!buf_empty)      state_d = ST_WR;
            end
            ST_WR:     if (bus_ack) state_d = ST_IDLE;
            ST_RD:     if (bus_ack) state_d = retry ? ST_FLUSH : ST_IDLE;
            ST_FLUSH:  if (bus_ack && buf_last) state_d = ST_REPLAY;
            ST_REPLAY: if (bus_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and capture of the read being served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_addr_q <= '0;
            rd_ci_q   <= 1'b0;
            inh_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && core_req && !core_we) begin
                rd_addr_q <= core_addr;
                rd_ci_q   <= core_ci;
                inh_q     <= !buf_empty;
            end
        end
    end
endmodule

// File: rtl/wbio_top.sv
// Posted-write buffer with I/O read interlock: the FIFO holds posted
// writes, the sequencer owns the bus. Assumes the core holds a request
// stable until core_ready and that devices sample decode only with ack.
module wbio_top #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_ci,
    output logic              core_ready,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_rcache,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_inhibit,
    input  logic              bus_ack,
    input  logic              bus_decode_n,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic              push, pop, buf_full, buf_empty, buf_last;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;

    wbio_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(core_addr), .push_data(core_wdata),
        .pop(pop), .head_addr(head_addr), .head_data(head_data),
        .full(buf_full), .empty(buf_empty), .last(buf_last)
    );

    wbio_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_ci(core_ci), .core_ready(core_ready), .core_rdata(core_rdata),
        .core_rcache(core_rcache),
        .buf_full(buf_full), .buf_empty(buf_empty), .buf_last(buf_last),
        .head_addr(head_addr), .head_data(head_data),
        .push(push), .pop(pop),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_inhibit(bus_inhibit),
        .bus_ack(bus_ack), .bus_decode_n(bus_decode_n), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/wbio_chk.sv
// Protocol checker for wbio_top, attached by bind below.
module wbio_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_req,
    input logic              core_we,
    input logic              core_ready,
    input logic              core_rcache,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_inhibit,
    input logic              bus_ack,
    input logic              bus_decode_n,
    input logic              buf_full,
    input logic              buf_empty
);
    // R4
    inh_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_inhibit |-> (bus_req && !bus_we));

    // R4
    inh_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_inhibit) |-> !buf_empty);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !(core_req && core_we && core_ready));

    // R9
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                                   && $stable(bus_wdata) && $stable(bus_inhibit)));

    // R7
    io_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_we && core_ready && !bus_decode_n) |-> !core_rcache);

    // R5
    flush_follows_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_inhibit && !bus_decode_n) |=> (bus_req && bus_we));

    // R8
    discard_on_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_inhibit && !bus_decode_n) |-> !core_ready);
endmodule

bind wbio_top wbio_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_ready(core_ready),
    .core_rcache(core_rcache),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_inhibit(bus_inhibit), .bus_ack(bus_ack),
    .bus_decode_n(bus_decode_n), .buf_full(buf_full), .buf_empty(buf_empty)
);

// File: tb/wbio_top_tb.sv
// Bench: device stub (window F decodes, E is a silent data port, rest memory),
// random and directed core traffic, expected values from bench functions.
module wbio_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0, core_ci = 1'b0;
    logic [15:0] core_addr = '0, core_wdata = '0;
    logic        core_ready, core_rcache;
    logic [15:0] core_rdata;
    logic        bus_req, bus_we, bus_inhibit;
    logic [15:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0, bus_decode_n = 1'b1;
    logic [15:0] bus_rdata = '0;

    int errors = 0, checks = 0, cyc = 0;
    logic [31:0] exp_q [$];
    bit          kind_q [$];
    bit          inhl_q [$];
    logic [15:0] io_model [16];
    logic [15:0] dev_mem [16];
    bit  hold = 1'b0, in_cyc = 1'b0, rd_first = 1'b0, rd_inh = 1'b0;
    int  wcnt = 0, rd_pend = 0;

    wbio_top u_dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [15:0] a);
        return (a[15:12] == 4'hF) ? io_model[a[3:0]] : (a ^ 16'h5A5A);
    endfunction

    function automatic bit exp_cache(input logic [15:0] a, input bit ci);
        return !ci && (a[15:12] != 4'hF);
    endfunction

    // Device stub: decides ack for the coming edge at each falling edge.
    always @(negedge clk) begin
        bus_ack = 1'b0; bus_decode_n = 1'b1; bus_rdata = '0;
        if (!rst_n) begin
            in_cyc = 1'b0;
        end else if (bus_req) begin
            if (!in_cyc) begin
                in_cyc = 1'b1;
                wcnt = int'($urandom % 3);
                kind_q.push_back(!bus_we);
                inhl_q.push_back(bus_inhibit);
                if (bus_we) chk(!bus_inhibit, "R4", "inhibit on write", bus_inhibit, 0);
                else chk(bus_inhibit == (exp_q.size() != 0), "R4", "inhibit at read start",
                         bus_inhibit, exp_q.size() != 0);
                if (!bus_we && rd_first) begin
                    rd_first = 1'b0; rd_pend = exp_q.size(); rd_inh = bus_inhibit;
                end
            end
            if (!hold && wcnt == 0) begin
                bus_ack = 1'b1; in_cyc = 1'b0;
                if (bus_we) begin
                    if (exp_q.size() == 0) chk(0, "R1", "unexpected bus write", bus_addr, 0);
                    else begin
                        chk(exp_q[0] == {bus_addr, bus_wdata}, "R1", "write order/content",
                            {bus_addr, bus_wdata}, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    if (bus_addr[15:12] == 4'hF) dev_mem[bus_addr[3:0]] = bus_wdata;
                end else if (bus_addr[15:12] == 4'hF) begin
                    bus_decode_n = 1'b0;
                    bus_rdata = bus_inhibit ? 16'hDEAD : dev_mem[bus_addr[3:0]];
                end else begin
                    bus_rdata = bus_addr ^ 16'h5A5A;
                end
            end else if (wcnt > 0) wcnt--;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        bit done = 1'b0;
        core_req = 1'b1; core_we = 1'b1; core_addr = a; core_wdata = d; core_ci = 1'b0;
        while (!done) begin
            #5;
            if (core_ready) begin
                done = 1'b1;
                exp_q.push_back({a, d});
                if (a[15:12] == 4'hF) io_model[a[3:0]] = d;
            end
            @(negedge clk);
        end
        core_req = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input bit ci);
        bit done = 1'b0;
        core_req = 1'b1; core_we = 1'b0; core_addr = a; core_ci = ci; rd_first = 1'b1;
        while (!done) begin
            #5;
            if (core_ready) begin
                done = 1'b1;
                chk(core_rdata == exp_rd(a), (a[15:12] == 4'hF) ? "R5" : "R6",
                    "read data", core_rdata, exp_rd(a));
                chk(core_rcache == exp_cache(a, ci), "R7", "cacheable flag",
                    core_rcache, exp_cache(a, ci));
                if (a[15:12] == 4'hF)
                    chk(exp_q.size() == 0, "R8", "writes pending at I/O read end",
                        exp_q.size(), 0);
                else
                    chk(exp_q.size() == rd_pend, "R6", "writes kept across memory read",
                        exp_q.size(), rd_pend);
            end
            @(negedge clk);
        end
        core_req = 1'b0;
    endtask

    task automatic settle();
        hold = 1'b0;
        while (exp_q.size() != 0 || bus_req) @(negedge clk);
        repeat (2) @(negedge clk);
        kind_q.delete(); inhl_q.delete();
    endtask

    function automatic logic [15:0] rnd_addr();
        logic [15:0] a = 16'($urandom);
        case ($urandom % 3)
            0:       a[15:12] = 4'hF;
            1:       a[15:12] = 4'hE;
            default: a[15:12] = 4'h0;
        endcase
        return a;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin io_model[i] = '0; dev_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!bus_req, "R10", "bus_req in reset", bus_req, 0);
        chk(!core_ready, "R10", "core_ready in reset", core_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req, "R10", "bus_req after reset", bus_req, 0);
        do_read(16'hF000, 1'b0);
        chk(inhl_q.size() == 1 && !inhl_q[0], "R10", "first read uninhibited (buffer empty)",
            inhl_q.size(), 1);
        settle();

        // R2: fill the buffer against a stalled bus, fifth write must wait
        hold = 1'b1;
        for (int i = 1; i <= 4; i++) do_write(16'h0100 + 16'(i), 16'hA000 + 16'(i));
        core_req = 1'b1; core_we = 1'b1; core_addr = 16'h0105; core_wdata = 16'hA005;
        for (int i = 0; i < 3; i++) begin
            #5; chk(!core_ready, "R2", "write accepted while full", core_ready, 0);
            @(negedge clk);
        end
        hold = 1'b0;
        do_write(16'h0105, 16'hA005);
        settle();
        chk(exp_q.size() == 0, "R1", "all posted writes drained", exp_q.size(), 0);

        // R3: read overtakes the second buffered write
        hold = 1'b1;
        do_write(16'h0010, 16'h1010);
        do_write(16'h0011, 16'h1011);
        fork
            do_read(16'h0020, 1'b0);
            begin repeat (3) @(negedge clk); hold = 1'b0; end
        join
        settle();

        // R5: I/O read behind buffered I/O writes: flush then replay
        hold = 1'b1;
        do_write(16'hF003, 16'h1111);
        do_write(16'hF003, 16'h2222);
        fork
            do_read(16'hF003, 1'b0);
            begin repeat (3) @(negedge clk); hold = 1'b0; end
        join
        chk(kind_q.size() == 4, "R5", "bus cycle count", kind_q.size(), 4);
        if (kind_q.size() == 4) begin
            chk({kind_q[0], kind_q[1], kind_q[2], kind_q[3]} == 4'b0101, "R5",
                "cycle kinds W R W R", {kind_q[0], kind_q[1], kind_q[2], kind_q[3]}, 4'b0101);
            chk(inhl_q[1] && !inhl_q[3], "R5", "inhibit first read only, not replay",
                {inhl_q[1], inhl_q[3]}, 2'b10);
        end
        settle();

        // R3 result of the earlier staged read is checked here via a fresh stage
        hold = 1'b1;
        do_write(16'h0030, 16'h3030);
        do_write(16'h0031, 16'h3031);
        fork
            do_read(16'h0040, 1'b1);
            begin repeat (3) @(negedge clk); hold = 1'b0; end
        join
        settle();
        // (logs were cleared by settle; re-stage to inspect ordering)
        hold = 1'b1;
        do_write(16'h0050, 16'h5050);
        do_write(16'h0051, 16'h5051);
        fork
            do_read(16'h0060, 1'b0);
            begin repeat (3) @(negedge clk); hold = 1'b0; end
        join
        chk(kind_q.size() >= 2 && kind_q[1], "R3", "read issued before remaining write",
            kind_q.size() >= 2 ? kind_q[1] : 0, 1);

        // R6: data port read overtakes pending write, stays cacheable, no replay
        settle();
        hold = 1'b1;
        do_write(16'hF005, 16'h5555);
        do_write(16'hF006, 16'h6666);
        fork
            do_read(16'hE100, 1'b0);
            begin repeat (3) @(negedge clk); hold = 1'b0; end
        join
        chk(rd_inh, "R6", "data-port read was inhibited", rd_inh, 1);
        chk(kind_q.size() == 2, "R6", "no replay before completion", kind_q.size(), 2);
        settle();
        chk(kind_q.size() == 0 && exp_q.size() == 0, "R6", "kept write drained later",
            exp_q.size(), 0);

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 10);
            if (r < 4) do_write(rnd_addr(), 16'($urandom));
            else if (r < 9) do_read(rnd_addr(), bit'($urandom % 2));
            else repeat (int'($urandom % 4)) @(negedge clk);
        end
        settle();
        chk(exp_q.size() == 0, "R1", "random traffic fully drained", exp_q.size(), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule